// File: doc/BRIEF.md
# USB High-Speed Chirp Handshake Sequencer

This block sits on the link side of a USB device port and drives the transceiver-macrocell control fields through the high-speed detection handshake that follows a bus reset. When a reset-detected strobe arrives, it leaves the full-speed configuration, selects the high-speed transceiver and transmits continuous zero bytes with bit stuffing and NRZI turned off, which places a high-speed K on the bus. This is the device chirp.

An external line-state detector tells the block whether the host's alternating chirp has been recognised. Its flags are watched from the first cycle of the device chirp. High-speed terminations are committed only after a valid report and after the device chirp has ended. An invalid report, or silence until a timeout, sends the port back to full speed and raises a fallback result. Time is measured in microsecond ticks from the reset strobe. A fresh strobe restarts the whole sequence in any state.

Top module: `usb_hs_chirp_seq`

## Requirements
- R1: After hardware reset and before any strobe: op_mode=00, xcvr_sel=1 (full speed), term_sel=1 (full speed), tx_valid=0, tx_data=0, hs_mode=0, fs_fallback=0.
- R2: In the cycle after a reset strobe: op_mode=10 (no bit stuffing, no NRZI), xcvr_sel=0 (high speed), term_sel=1, tx_valid=1, tx_data=0.
- R3: tx_valid stays high while fewer than CHIRP_END_US ticks have passed since the last strobe. CHIRP_END_US is at least CHIRP_MIN_US.
- R4: The chirp ends, with tx_valid falling, one cycle after the tick count first stands at CHIRP_END_US or more while tx_ready is high. If tx_ready stays low, the chirp is forced to end once the count reaches CHIRP_MAX_US-1, so tx_valid is never high at a count of CHIRP_MAX_US.
- R5: When the chirp ends, tx_valid drops first while op_mode stays 10 for one cycle. op_mode then returns to 00 and xcvr_sel stays 0.
- R6: A valid flag while listening gives term_sel=0, xcvr_sel=0 and hs_mode=1 on the next cycle.
- R7: Valid or invalid flags seen during the chirp are remembered. term_sel stays 1 until the chirp has ended, and the remembered flag then decides the result.
- R8: An invalid flag gives xcvr_sel=1, term_sel=1 and fs_fallback=1 on the next cycle. Invalid wins over valid in the same cycle.
- R9: With no flag, the block falls back to full speed in the cycle after the tick count reaches LISTEN_TIMEOUT_US. A valid flag at one count below the timeout still succeeds.
- R10: A reset strobe in any state restarts the chirp and clears the tick count.
- R11: hs_mode and fs_fallback are never both high. term_sel=0 only occurs together with xcvr_sel=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| bus_reset_seen | input | 1 | One-cycle strobe marking the start of a bus reset |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| chirp_valid | input | 1 | Detector reports a valid host chirp |
| chirp_invalid | input | 1 | Detector reports an invalid host chirp |
| tx_ready | input | 1 | Transceiver accepted the current byte |
| op_mode | output | 2 | Operating mode: 00 normal, 10 no stuffing/NRZI |
| xcvr_sel | output | 1 | Transceiver select: 0 high speed, 1 full speed |
| term_sel | output | 1 | Termination select: 0 high speed, 1 full speed |
| tx_valid | output | 1 | Transmit data valid |
| tx_data | output | DATA_W | Transmit byte, always zero |
| hs_mode | output | 1 | Handshake succeeded |
| fs_fallback | output | 1 | Handshake failed, full speed kept |

## Verification
The bench builds the block with CHIRP_MIN_US=10, CHIRP_END_US=20, CHIRP_MAX_US=70 and LISTEN_TIMEOUT_US=100. This brings the chirp end, the forced end under a stalled tx_ready, and the listen timeout within a few hundred cycles. At these values the one-below-timeout and at-timeout boundaries can be reached exactly, and so can a restart partway through the chirp, where a timer that was not cleared would end the chirp early.

// File: rtl/chirp_pkg.sv
package chirp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CHIRP  = 3'd1,
    ST_STOP   = 3'd2,
    ST_LISTEN = 3'd3,
    ST_HS     = 3'd4,
    ST_FS_FB  = 3'd5
  } chirp_state_e;

  localparam logic [1:0] OPM_NORMAL = 2'b00;
  localparam logic [1:0] OPM_RAW    = 2'b10;
  localparam logic       SEL_HS     = 1'b0;
  localparam logic       SEL_FS     = 1'b1;

  // elapsed microseconds have reached a mark
  function automatic logic reached(input int unsigned elapsed, input int unsigned mark);
    return elapsed >= mark;
  endfunction

  // chirp may stop: past the planned end at a byte boundary, or at the hard limit
  function automatic logic chirp_may_end(input int unsigned elapsed, input int unsigned end_us,
                                         input int unsigned max_us, input logic ready);
    return (reached(elapsed, end_us) && ready) || reached(elapsed, max_us - 1);
  endfunction

endpackage

// File: rtl/chirp_timer.sv
module chirp_timer #(
  parameter int unsigned LIMIT = 8000,
  parameter int unsigned CW    = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          tick,
  output logic [CW-1:0] elapsed
);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  wire at_top = (elapsed == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              elapsed <= '0;
    else if (clear)          elapsed <= '0;
    else if (tick && !at_top) elapsed <= elapsed + 1'b1;
  end

  p_saturate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(at_top) && !$past(clear)) |-> at_top);

endmodule

// File: rtl/chirp_ctrl.sv
module chirp_ctrl
  import chirp_pkg::*;
#(
  parameter int unsigned CHIRP_END_US      = 2000,
  parameter int unsigned CHIRP_MAX_US      = 7000,
  parameter int unsigned LISTEN_TIMEOUT_US = 8000,
  parameter int unsigned CW                = $clog2(LISTEN_TIMEOUT_US + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         chirp_valid,
  input  logic         chirp_invalid,
  input  logic         tx_ready,
  input  logic [CW-1:0] elapsed,
  output chirp_state_e state
);
  chirp_state_e nxt;
  logic valid_seen, invalid_seen;

  wire in_chirp_phase = (state == ST_CHIRP) || (state == ST_STOP);
  wire chirp_done     = chirp_may_end(32'(elapsed), CHIRP_END_US, CHIRP_MAX_US, tx_ready);
  wire timed_out      = reached(32'(elapsed), LISTEN_TIMEOUT_US);
  wire any_invalid    = chirp_invalid || invalid_seen;
  wire any_valid      = chirp_valid || valid_seen;
  wire go_fb          = any_invalid || (!any_valid && timed_out);
  wire go_hs          = !any_invalid && any_valid;

  always_comb begin
    nxt = state;
    case (state)
      ST_CHIRP:  if (chirp_done) nxt = ST_STOP;
      ST_STOP:   nxt = ST_LISTEN;
      ST_LISTEN: begin
        if (go_fb)      nxt = ST_FS_FB;
        else if (go_hs) nxt = ST_HS;
      end
      default:   nxt = state;
    endcase
    if (restart) nxt = ST_CHIRP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      valid_seen   <= 1'b0;
      invalid_seen <= 1'b0;
    end else begin
      state <= nxt;
      if (restart) begin
        valid_seen   <= 1'b0;
        invalid_seen <= 1'b0;
      end else if (in_chirp_phase) begin
        valid_seen   <= valid_seen | chirp_valid;
        invalid_seen <= invalid_seen | chirp_invalid;
      end
    end
  end

  p_min_chirp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_CHIRP && state == ST_STOP) |-> $past(elapsed) >= CW'(CHIRP_END_US)
                                                     || !$past(tx_ready));
  p_invalid_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LISTEN && chirp_invalid && !restart) |=> state == ST_FS_FB);
  p_no_early_hs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HS && $past(state) != ST_HS) |-> $past(state) == ST_LISTEN);

endmodule

// File: rtl/chirp_outmap.sv
module chirp_outmap
  import chirp_pkg::*;
(
  input  chirp_state_e state,
  output logic [1:0]   op_mode,
  output logic         xcvr_sel,
  output logic         term_sel,
  output logic         tx_valid,
  output logic         hs_mode,
  output logic         fs_fallback
);
  always_comb begin
    op_mode     = OPM_NORMAL;
    xcvr_sel    = SEL_FS;
    term_sel    = SEL_FS;
    tx_valid    = 1'b0;
    hs_mode     = 1'b0;
    fs_fallback = 1'b0;
    case (state)
      ST_CHIRP: begin
        op_mode  = OPM_RAW;
        xcvr_sel = SEL_HS;
        tx_valid = 1'b1;
      end
      ST_STOP: begin
        op_mode  = OPM_RAW;
        xcvr_sel = SEL_HS;
      end
      ST_LISTEN: xcvr_sel = SEL_HS;
      ST_HS: begin
        xcvr_sel = SEL_HS;
        term_sel = SEL_HS;
        hs_mode  = 1'b1;
      end
      ST_FS_FB: fs_fallback = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/usb_hs_chirp_seq.sv
module usb_hs_chirp_seq
  import chirp_pkg::*;
#(
  parameter int unsigned CHIRP_MIN_US      = 1000,
  parameter int unsigned CHIRP_END_US      = 2000,
  parameter int unsigned CHIRP_MAX_US      = 7000,
  parameter int unsigned LISTEN_TIMEOUT_US = 8000,
  parameter int unsigned DATA_W            = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset_seen,
  input  logic              us_tick,
  input  logic              chirp_valid,
  input  logic              chirp_invalid,
  input  logic              tx_ready,
  output logic [1:0]        op_mode,
  output logic              xcvr_sel,
  output logic              term_sel,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              hs_mode,
  output logic              fs_fallback
);
  localparam int unsigned CW = $clog2(LISTEN_TIMEOUT_US + 1);

  logic [CW-1:0] elapsed;
  chirp_state_e  state;

  chirp_timer #(.LIMIT(LISTEN_TIMEOUT_US), .CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(bus_reset_seen), .tick(us_tick), .elapsed(elapsed)
  );

  chirp_ctrl #(
    .CHIRP_END_US(CHIRP_END_US), .CHIRP_MAX_US(CHIRP_MAX_US),
    .LISTEN_TIMEOUT_US(LISTEN_TIMEOUT_US), .CW(CW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .restart(bus_reset_seen),
    .chirp_valid(chirp_valid), .chirp_invalid(chirp_invalid),
    .tx_ready(tx_ready), .elapsed(elapsed), .state(state)
  );

  chirp_outmap u_map (
    .state(state), .op_mode(op_mode), .xcvr_sel(xcvr_sel), .term_sel(term_sel),
    .tx_valid(tx_valid), .hs_mode(hs_mode), .fs_fallback(fs_fallback)
  );

  assign tx_data = '0;

  p_chirp_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> elapsed < CW'(CHIRP_MAX_US));
  p_min_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_valid) |-> $past(elapsed) >= CW'(CHIRP_MIN_US));
  p_drop_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tx_valid) && !$past(bus_reset_seen)) |-> op_mode == OPM_RAW ##1 (bus_reset_seen
      || $past(bus_reset_seen) || op_mode == OPM_NORMAL));
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_seen |=> (tx_valid && term_sel == SEL_FS && elapsed == '0));
  p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_mode && fs_fallback));
  p_term_needs_xcvr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (term_sel == SEL_HS) |-> (xcvr_sel == SEL_HS));
  p_hs_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_mode) |-> $past(state) == ST_LISTEN);

endmodule

// File: tb/usb_hs_chirp_seq_tb.sv
module usb_hs_chirp_seq_tb;
  localparam int unsigned T_MIN = 10, T_END = 20, T_MAX = 70, T_TO = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_reset_seen = 0, us_tick = 0, chirp_valid = 0, chirp_invalid = 0, tx_ready = 1;
  logic [1:0] op_mode;
  logic xcvr_sel, term_sel, tx_valid, hs_mode, fs_fallback;
  logic [7:0] tx_data;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  usb_hs_chirp_seq #(.CHIRP_MIN_US(T_MIN), .CHIRP_END_US(T_END), .CHIRP_MAX_US(T_MAX),
                     .LISTEN_TIMEOUT_US(T_TO), .DATA_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_reset_seen(bus_reset_seen), .us_tick(us_tick),
    .chirp_valid(chirp_valid), .chirp_invalid(chirp_invalid), .tx_ready(tx_ready),
    .op_mode(op_mode), .xcvr_sel(xcvr_sel), .term_sel(term_sel), .tx_valid(tx_valid),
    .tx_data(tx_data), .hs_mode(hs_mode), .fs_fallback(fs_fallback));

  // {expect_hs, listen ticks before event, valid, invalid}
  localparam logic [10:0] VEC [0:4] = '{
    {1'b1, 8'd0,  1'b1, 1'b0},
    {1'b0, 8'd0,  1'b0, 1'b1},
    {1'b1, 8'd79, 1'b1, 1'b0},
    {1'b0, 8'd80, 1'b0, 1'b0},
    {1'b0, 8'd5,  1'b1, 1'b1}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin us_tick = 1; @(negedge clk); end
    us_tick = 0;
  endtask

  task automatic strobe();
    bus_reset_seen = 1; @(negedge clk); bus_reset_seen = 0;
  endtask

  task automatic run_to_listen();
    strobe(); tick(T_END); @(negedge clk); @(negedge clk);
  endtask

  task automatic pack_fields(input string tag, input int opm, input int xs, input int ts, input int tv);
    check({tag, " op_mode"}, op_mode, opm);
    check({tag, " xcvr_sel"}, xcvr_sel, xs);
    check({tag, " term_sel"}, term_sel, ts);
    check({tag, " tx_valid"}, tx_valid, tv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    pack_fields("R1 idle", 0, 1, 1, 0);
    check("R1 tx_data", tx_data, 0);
    check("R1 hs_mode", hs_mode, 0);
    check("R1 fs_fallback", fs_fallback, 0);
    rst_n = 1; @(negedge clk);
    pack_fields("R1 after release", 0, 1, 1, 0);

    // table walk
    for (int i = 0; i < 5; i++) begin
      string tag;
      logic [10:0] v = VEC[i];
      tag = v[0] ? "R8" : (v[1] ? "R6" : "R9");
      run_to_listen();
      tick(int'(v[9:2]));
      chirp_valid = v[1]; chirp_invalid = v[0];
      @(negedge clk);
      chirp_valid = 0; chirp_invalid = 0;
      check({tag, " hs_mode"}, hs_mode, v[10]);
      check({tag, " fs_fallback"}, fs_fallback, !v[10]);
      check({tag, " term_sel"}, term_sel, !v[10]);
      check({tag, " xcvr_sel"}, xcvr_sel, !v[10]);
    end

    // R2 chirp fields, R3 minimum, R4 end, R5 ordering
    strobe();
    pack_fields("R2 chirp", 2, 0, 1, 1);
    check("R2 tx_data", tx_data, 0);
    check("R11 exclusive", hs_mode & fs_fallback, 0);
    tick(T_END - 1);
    check("R3 still chirping", tx_valid, 1);
    tick(1);
    check("R4 one cycle later", tx_valid, 1);
    @(negedge clk);
    pack_fields("R5 tx drop first", 2, 0, 1, 0);
    @(negedge clk);
    pack_fields("R5 normal mode", 0, 0, 1, 0);

    // R4 forced end with tx_ready low
    tx_ready = 0;
    strobe();
    tick(T_MAX - 1);
    check("R4 stalled still valid", tx_valid, 1);
    @(negedge clk);
    check("R4 forced end", tx_valid, 0);
    tx_ready = 1;

    // R7 latched valid during chirp
    strobe(); tick(5);
    chirp_valid = 1; @(negedge clk); chirp_valid = 0;
    check("R7 term held fs", term_sel, 1);
    check("R7 chirp continues", tx_valid, 1);
    tick(T_END - 5);
    @(negedge clk); @(negedge clk);
    check("R7 no early hs", hs_mode, 0);
    @(negedge clk);
    check("R7 hs after end", hs_mode, 1);
    check("R7 term hs", term_sel, 0);

    // R7 latched invalid during chirp
    strobe(); tick(3);
    chirp_invalid = 1; @(negedge clk); chirp_invalid = 0;
    tick(T_END - 3); @(negedge clk); @(negedge clk); @(negedge clk);
    check("R7 latched invalid", fs_fallback, 1);

    // R10 restart mid chirp clears timer, restart from hs
    strobe(); tick(15);
    strobe();
    tick(T_END - 1);
    check("R10 timer cleared", tx_valid, 1);
    tick(1); @(negedge clk);
    check("R10 end after restart", tx_valid, 0);
    @(negedge clk);
    chirp_valid = 1; @(negedge clk); chirp_valid = 0;
    check("R6 reached hs", hs_mode, 1);
    strobe();
    pack_fields("R10 restart from hs", 2, 0, 1, 1);
    check("R10 hs cleared", hs_mode, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule